// File: doc/BRIEF.md
# Multi-Mode Gated Event Counter

This block is a decimal counting core for bench instruments. It measures the frequency of a logic signal, times the width of one pulse, or times the interval between two pulses. A single chain of BCD digits serves every mode. What it counts, and when it counts, depends on a mode input, a timer sub-mode input, an edge-polarity input and a range selector. The range selector picks one reference strobe from an internal decade timebase.

In frequency mode, the selected strobe drives a divide-by-two gate. The gate makes counting windows and rest windows of equal length. Rising edges of the measured signal are counted only inside a window. The digits are cleared when the next window opens, so during the rest window they hold the last result. A free-running range setting counts the input continuously, with no window.

In timer mode, the block counts reference strobes instead. In pulse-width timing it counts while the measured signal is high. In start/stop timing, one rising edge starts the count and the next rising edge stops it. After one measurement the result locks until it is cleared. A hold button freezes the count. A clear button restarts the measurement. When the top digit reaches 8, counting stops and the hold indicator lights.

Top module: `gated_event_counter`

## Requirements
- R1: While `rst_n` is low, all state is cleared. After reset, `count_bcd` reads zero and both `hold_led` and `win_done` are low.
- R2: `sig_in`, `hold_btn` and `clr_btn` each pass through two flip-flop stages before use. The measured signal is the synchronised input XOR `pol_inv`, so `pol_inv`=1 swaps the meaning of high/low and of rising/falling edges.
- R3: Frequency mode is `mode_timer`=0. Each selected strobe toggles a gate flag. A rising edge of the measured signal adds one to the count only while the gate flag is high, and `gate_led` shows the gate flag. Every nibble of `count_bcd` is a BCD digit (0 to 9), least significant digit in bits [3:0].
- R4: In frequency mode, a selected strobe seen while the gate flag is low opens a window and clears the count, unless the hold latch is set. `win_done` is high exactly in the cycle where a selected strobe arrives while the gate flag is high.
- R5: `range_sel` codes 0 to 4 pick strobes from fastest to slowest. Their periods are BASE_DIV, then BASE_DIV·FIRST_DIV, and each further code multiplies the period by DECADE. Codes 5 to 7 are the free-running setting: in frequency mode every rising edge counts and `gate_led` stays high; in timer mode nothing is counted.
- R6: In timer mode (`mode_timer`=1), the count advances on selected strobes, never on edges of the input.
- R7: In pulse-width timing (`ss_mode`=0), strobes are counted while the measured signal is high, and `gate_led` follows the measured signal. A falling edge of the measured signal sets the lock.
- R8: In start/stop timing (`ss_mode`=1), each rising edge of the measured signal toggles a run flag while unlocked, and `gate_led` shows the run flag. The rising edge that ends a run also sets the lock.
- R9: While the lock is set in timer mode, the count does not change and further pulses have no effect on it. `hold_led` stays high until a clear.
- R10: When the most significant digit equals 8, the count stops advancing and `hold_led` is high. With eight digits this is a count of 80,000,000.
- R11: A synchronised `hold_btn` sets a hold latch. While the latch is set, the count is frozen in every mode (no increment, no window clear) and `hold_led` is high.
- R12: A synchronised `clr_btn` clears the digits, the lock, the hold latch and the run flag on the next edge. The clear takes priority over hold and over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sig_in | input | 1 | Logic-level signal to be measured |
| pol_inv | input | 1 | 1 inverts the measured signal (falling-edge operation) |
| mode_timer | input | 1 | 0 frequency mode, 1 timer mode |
| ss_mode | input | 1 | Timer sub-mode: 0 pulse width, 1 start/stop |
| range_sel | input | 3 | Reference strobe select 0..4, 5..7 free-running |
| hold_btn | input | 1 | Hold / manual stop button |
| clr_btn | input | 1 | Clear button |
| count_bcd | output | 4*NDIG | BCD count, least significant digit in bits [3:0] |
| gate_led | output | 1 | Gate / run indicator |
| hold_led | output | 1 | Hold, lock or overflow indicator |
| win_done | output | 1 | Marks the last cycle of a frequency count window |

## Verification
A behavioural model predicts every output on every cycle. The input is tried in several forms:
- Square waves of different periods under slow and fast frequency windows. These separate window opening, counting and clearing.
- The same input with inverted polarity. This shows whether the XOR is applied before edge detection.
- Single long pulses and pulse pairs in timer mode. These tell pulse-width timing apart from start/stop timing, and show that the lock ignores later pulses.
- Continuous fast toggling on the free-running range. This drives the count into overflow.

Hold presses between bursts of edges test the freeze. A free-running range in timer mode shows that the input is never counted there.

// File: rtl/gec_pkg.sv
`timescale 1ns/1ps
package gec_pkg;
  localparam int REF_COUNT = 5;
  localparam logic [2:0] RANGE_FREE = 3'd5;
  typedef logic [3:0] bcd_t;
endpackage

// File: rtl/gec_sync.sv
`timescale 1ns/1ps
module gec_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic stage1_q, stage2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1_q <= 1'b0;
        stage2_q <= 1'b0;
      end else begin
        stage1_q <= d[i];
        stage2_q <= stage1_q;
      end
    end
    assign q[i] = stage2_q;
  end
endmodule

// File: rtl/gec_timebase.sv
`timescale 1ns/1ps
module gec_timebase #(
  parameter int BASE_DIV  = 125,
  parameter int FIRST_DIV = 1000,
  parameter int DECADE    = 10,
  parameter int NREF      = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [NREF-1:0] tick
);
  for (genvar k = 0; k < NREF; k++) begin : g_stage
    localparam int DIV = (k == 0) ? BASE_DIV : ((k == 1) ? FIRST_DIV : DECADE);
    localparam int SW  = $clog2(DIV) + 1;
    logic [SW-1:0] cnt_q, cnt_d;
    logic          step;
    if (k == 0) begin : g_first
      assign step = 1'b1;
    end else begin : g_chain
      assign step = tick[k-1];
    end
    assign tick[k] = step && (cnt_q == SW'(DIV - 1));
    always_comb begin
      cnt_d = cnt_q;
      if (step) cnt_d = tick[k] ? '0 : cnt_q + 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/gec_bcd_counter.sv
`timescale 1ns/1ps
module gec_bcd_counter
  import gec_pkg::*;
#(
  parameter int NDIG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  output logic [4*NDIG-1:0] value
);
  logic [NDIG:0] carry;
  assign carry[0] = inc;

  for (genvar i = 0; i < NDIG; i++) begin : g_digit
    bcd_t dig_q, dig_d;
    logic at_nine;
    assign at_nine    = (dig_q == 4'd9);
    assign carry[i+1] = carry[i] && at_nine;
    always_comb begin
      dig_d = dig_q;
      if (clr)           dig_d = '0;
      else if (carry[i]) dig_d = at_nine ? '0 : dig_q + 4'd1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dig_q <= '0;
      else        dig_q <= dig_d;
    end
    assign value[4*i +: 4] = dig_q;
  end
endmodule

// File: rtl/gated_event_counter.sv
`timescale 1ns/1ps
module gated_event_counter
  import gec_pkg::*;
#(
  parameter int NDIG      = 8,
  parameter int BASE_DIV  = 125,
  parameter int FIRST_DIV = 1000,
  parameter int DECADE    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sig_in,
  input  logic              pol_inv,
  input  logic              mode_timer,
  input  logic              ss_mode,
  input  logic [2:0]        range_sel,
  input  logic              hold_btn,
  input  logic              clr_btn,
  output logic [4*NDIG-1:0] count_bcd,
  output logic              gate_led,
  output logic              hold_led,
  output logic              win_done
);
  localparam int CW = 4 * NDIG;

  logic                 sig_s, hold_s, clr_s;
  logic [REF_COUNT-1:0] tick;
  logic                 sel_tick, free_run;
  logic                 meas, rise, fall, run, ovf, win_clr, inc;
  logic                 meas_q, gate_q, ss_q, lock_q, hold_q;
  logic                 gate_d, ss_d, lock_d, hold_d;

  gec_sync #(.W(3)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sig_in, hold_btn, clr_btn}),
    .q     ({sig_s, hold_s, clr_s})
  );

  gec_timebase #(
    .BASE_DIV  (BASE_DIV),
    .FIRST_DIV (FIRST_DIV),
    .DECADE    (DECADE),
    .NREF      (REF_COUNT)
  ) u_timebase (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  always_comb begin
    case (range_sel)
      3'd0:    sel_tick = tick[0];
      3'd1:    sel_tick = tick[1];
      3'd2:    sel_tick = tick[2];
      3'd3:    sel_tick = tick[3];
      3'd4:    sel_tick = tick[4];
      default: sel_tick = 1'b0;
    endcase
  end

  assign free_run = (range_sel >= RANGE_FREE);
  assign meas     = sig_s ^ pol_inv;
  assign rise     = meas && !meas_q;
  assign fall     = !meas && meas_q;
  assign run      = ss_mode ? ss_q : meas;
  assign ovf      = (count_bcd[CW-1 -: 4] == 4'd8);
  assign win_clr  = !mode_timer && sel_tick && !gate_q && !hold_q;
  assign inc      = !ovf && !hold_q &&
                    (mode_timer ? (sel_tick && run && !lock_q)
                                : (rise && (free_run || gate_q)));

  always_comb begin
    gate_d = gate_q ^ sel_tick;
    hold_d = hold_q;
    ss_d   = ss_q;
    lock_d = lock_q;
    if (hold_s) hold_d = 1'b1;
    if (mode_timer && ss_mode && rise && !lock_q) begin
      ss_d = !ss_q;
      if (ss_q) lock_d = 1'b1;
    end
    if (mode_timer && !ss_mode && fall) lock_d = 1'b1;
    if (clr_s) begin
      hold_d = 1'b0;
      ss_d   = 1'b0;
      lock_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meas_q <= 1'b0;
      gate_q <= 1'b0;
      ss_q   <= 1'b0;
      lock_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meas_q <= meas;
      gate_q <= gate_d;
      ss_q   <= ss_d;
      lock_q <= lock_d;
      hold_q <= hold_d;
    end
  end

  gec_bcd_counter #(.NDIG(NDIG)) u_digits (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_s || win_clr),
    .inc   (inc),
    .value (count_bcd)
  );

  assign gate_led = mode_timer ? run : (free_run || gate_q);
  assign hold_led = hold_q || lock_q || ovf;
  assign win_done = !mode_timer && sel_tick && gate_q;
endmodule

// File: rtl/gec_checker.sv
`timescale 1ns/1ps
module gec_checker #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] count_bcd,
  input logic          gate_led,
  input logic          hold_led,
  input logic          win_done,
  input logic          mode_timer,
  input logic          clr_s,
  input logic          hold_q,
  input logic          lock_q,
  input logic          win_clr,
  input logic          ovf
);
  function automatic logic digits_ok(input logic [CW-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < CW / 4; i++) if (v[4*i +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  a_r12_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clr_s |=> (count_bcd == '0 && !hold_q && !lock_q));

  a_r11_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !clr_s) |=> $stable(count_bcd));

  a_r9_lock_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && mode_timer && !clr_s) |=> $stable(count_bcd));

  a_r10_ovf_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr_s && !win_clr) |=> $stable(count_bcd));

  a_r10_ovf_led: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> hold_led);

  a_r3_bcd_digits: assert property (@(posedge clk) disable iff (!rst_n)
    digits_ok(count_bcd));

  a_r4_done_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |-> (gate_led && !mode_timer));
endmodule

bind gated_event_counter gec_checker #(.CW(4 * NDIG)) i_gec_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .count_bcd  (count_bcd),
  .gate_led   (gate_led),
  .hold_led   (hold_led),
  .win_done   (win_done),
  .mode_timer (mode_timer),
  .clr_s      (clr_s),
  .hold_q     (hold_q),
  .lock_q     (lock_q),
  .win_clr    (win_clr),
  .ovf        (ovf)
);

// File: tb/test_gated_event_counter.sv
`timescale 1ns/1ps
module test_gated_event_counter;
  localparam int ND    = 2;
  localparam int BD    = 2;
  localparam int FD    = 3;
  localparam int DD    = 2;
  localparam int OVF_V = 80;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sig_in = 1'b0, pol_inv = 1'b0, mode_timer = 1'b0, ss_mode = 1'b0;
  logic [2:0]    range_sel = 3'd4;
  logic          hold_btn = 1'b0, clr_btn = 1'b0;
  logic [4*ND-1:0] count_bcd;
  logic          gate_led, hold_led, win_done;

  int n_total = 0;
  int n_bad   = 0;
  string cur_req = "R1";
  bit    cmp_on = 1'b0;

  always #4 clk = ~clk;

  gated_event_counter #(.NDIG(ND), .BASE_DIV(BD), .FIRST_DIV(FD), .DECADE(DD)) i_gated_event_counter (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .pol_inv(pol_inv), .mode_timer(mode_timer),
    .ss_mode(ss_mode), .range_sel(range_sel), .hold_btn(hold_btn), .clr_btn(clr_btn),
    .count_bcd(count_bcd), .gate_led(gate_led), .hold_led(hold_led), .win_done(win_done)
  );

  // reference model state
  int  per [5];
  int  cyc, mv;
  bit  s1, s2, h1, h2, c1, c2, measd, g, ss, lock, hold;

  function automatic bit tick_at(int c, logic [2:0] r);
    if (r >= 3'd5) return 1'b0;
    return (c % per[r]) == per[r] - 1;
  endfunction

  function automatic logic [4*ND-1:0] to_bcd(int v);
    logic [4*ND-1:0] r;
    int x;
    x = v;
    for (int i = 0; i < ND; i++) begin
      r[4*i +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  initial begin
    per[0] = BD;
    per[1] = BD * FD;
    for (int k = 2; k < 5; k++) per[k] = per[k-1] * DD;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc = 0; mv = 0;
      s1 = 0; s2 = 0; h1 = 0; h2 = 0; c1 = 0; c2 = 0;
      measd = 0; g = 0; ss = 0; lock = 0; hold = 0;
    end else begin
      bit meas, rise, fall, st, free, ovf, run, wclr, inc, n_lock, n_ss, n_hold;
      meas = s2 ^ pol_inv;
      rise = meas && !measd;
      fall = !meas && measd;
      st   = tick_at(cyc, range_sel);
      free = range_sel >= 3'd5;
      ovf  = mv >= OVF_V;
      run  = ss_mode ? ss : meas;
      wclr = !mode_timer && st && !g && !hold;
      inc  = !ovf && !hold && (mode_timer ? (st && run && !lock) : (rise && (free || g)));
      n_lock = lock || (mode_timer && !ss_mode && fall) || (mode_timer && ss_mode && rise && ss && !lock);
      n_ss   = (mode_timer && ss_mode && rise && !lock) ? !ss : ss;
      n_hold = h2 ? 1'b1 : hold;
      if (c2) begin
        mv = 0; n_lock = 0; n_ss = 0; n_hold = 0;
      end else if (wclr) mv = 0;
      else if (inc) mv = mv + 1;
      lock = n_lock; ss = n_ss; hold = n_hold;
      if (st) g = !g;
      measd = meas;
      s2 = s1; s1 = sig_in;
      h2 = h1; h1 = hold_btn;
      c2 = c1; c1 = clr_btn;
      cyc = cyc + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      bit meas_now, st_now, free_now, e_gate, e_hold, e_done;
      logic [4*ND-1:0] e_cnt;
      meas_now = s2 ^ pol_inv;
      st_now   = tick_at(cyc, range_sel);
      free_now = range_sel >= 3'd5;
      e_cnt    = to_bcd(mv);
      e_gate   = mode_timer ? (ss_mode ? ss : meas_now) : (free_now || g);
      e_hold   = hold || lock || (mv >= OVF_V);
      e_done   = !mode_timer && st_now && g;
      n_total++;
      if (count_bcd !== e_cnt || gate_led !== e_gate || hold_led !== e_hold || win_done !== e_done) begin
        n_bad++;
        $display("FAIL %s cyc=%0d count=%h/%h gate=%b/%b hold=%b/%b done=%b/%b (actual/expected)",
                 cur_req, cyc, count_bcd, e_cnt, gate_led, e_gate, hold_led, e_hold, win_done, e_done);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic square(input int n, input int half);
    repeat (n) begin
      sig_in = 1'b1; wait_cyc(half);
      sig_in = 1'b0; wait_cyc(half);
    end
  endtask

  task automatic press_clr();
    clr_btn = 1'b1; wait_cyc(1);
    clr_btn = 1'b0; wait_cyc(4);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    // R1: reset state
    chk(count_bcd == '0, "R1", int'(count_bcd), 0);
    chk(hold_led == 1'b0, "R1", int'(hold_led), 0);
    chk(win_done == 1'b0, "R1", int'(win_done), 0);
    cmp_on = 1'b1;

    // R3 R4 R5: frequency windows, slow range
    cur_req = "R3";
    square(40, 2);
    cur_req = "R4";
    range_sel = 3'd2;
    square(60, 1);
    // R2: inverted polarity, range 3
    cur_req = "R2";
    pol_inv = 1'b1; range_sel = 3'd3;
    square(30, 3);
    pol_inv = 1'b0;

    // R10: free-running count to overflow
    cur_req = "R10";
    range_sel = 3'd5;
    press_clr();
    square(100, 1);
    wait_cyc(2);
    chk(count_bcd == 8'h80, "R10", int'(count_bcd), 'h80);
    chk(hold_led == 1'b1, "R10", int'(hold_led), 1);

    // R12: clear
    cur_req = "R12";
    press_clr();
    chk(count_bcd == '0, "R12", int'(count_bcd), 0);

    // R6 R7: pulse-width timing on the fastest strobe
    cur_req = "R7";
    mode_timer = 1'b1; ss_mode = 1'b0; range_sel = 3'd0;
    press_clr();
    sig_in = 1'b1; wait_cyc(20);
    sig_in = 1'b0; wait_cyc(8);
    chk(count_bcd != '0, "R6", int'(count_bcd), 10);
    chk(hold_led == 1'b1, "R7", int'(hold_led), 1);
    // R9: later pulse ignored while locked
    cur_req = "R9";
    square(3, 6);
    wait_cyc(4);

    // R2: inverted pulse-width, counts while input is low
    cur_req = "R2";
    pol_inv = 1'b1; sig_in = 1'b1;
    press_clr();
    sig_in = 1'b0; wait_cyc(16);
    sig_in = 1'b1; wait_cyc(6);
    pol_inv = 1'b0; sig_in = 1'b0;

    // R8: start/stop timing
    cur_req = "R8";
    ss_mode = 1'b1; range_sel = 3'd1;
    press_clr();
    sig_in = 1'b1; wait_cyc(2); sig_in = 1'b0; wait_cyc(60);
    sig_in = 1'b1; wait_cyc(2); sig_in = 1'b0; wait_cyc(6);
    chk(count_bcd != '0, "R8", int'(count_bcd), 10);
    cur_req = "R9";
    square(2, 5);
    wait_cyc(20);

    // R5: free-running code in timer mode counts nothing
    cur_req = "R5";
    ss_mode = 1'b0; range_sel = 3'd6;
    press_clr();
    square(10, 2);
    chk(count_bcd == '0, "R5", int'(count_bcd), 0);

    // R11: hold freezes free-running counting
    cur_req = "R11";
    mode_timer = 1'b0; range_sel = 3'd5;
    press_clr();
    square(10, 1);
    hold_btn = 1'b1; wait_cyc(1); hold_btn = 1'b0; wait_cyc(3);
    square(10, 1);
    chk(hold_led == 1'b1, "R11", int'(hold_led), 1);
    // R11: hold also blocks window clears
    range_sel = 3'd1;
    square(10, 2);
    cur_req = "R12";
    press_clr();
    chk(hold_led == 1'b0, "R12", int'(hold_led), 0);
    square(10, 2);

    cmp_on = 1'b0;
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

  initial begin
    #1600000;
    n_total++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end
endmodule